// File: doc/BRIEF.md
# Post-Modify Pointer Load/Store Unit

This block carries out memory accesses that take their address from a dedicated 16-bit pointer register. Each access uses the pointer as it stands. When the memory accepts the access, the pointer moves by a signed 8-bit step carried in the command. There are word and byte forms of both load and store. Two further commands write the pointer from immediates: one loads the low twelve bits and clears the top nibble, the other replaces only the top nibble.

A command presents an opcode, a register index, the register's current value, a step and an immediate. For stores the value is the data to write. For byte loads it supplies the upper byte that is kept in the merged result. Loads return their result on a registered write-back port one cycle after the memory handshake. The memory port is byte-addressed, 16 bits wide, with a lane mask. Its response comes in the same cycle as the grant.

Top module: `ptr_lsu`

## Requirements
- R1: Opcode 0 (word load) requests a read at the current pointer with mask 2'b11. One cycle after the grant, write-back is valid with the read word and the command's register index.
- R2: Opcode 1 (word store) requests a write at the current pointer with mask 2'b11 and write data equal to the register value. It produces no write-back.
- R3: Opcode 2 (byte load) takes read bits 7:0 when pointer bit 0 is 0 and bits 15:8 when it is 1. The write-back is that byte in bits 7:0, with bits 15:8 copied from the supplied register value.
- R4: Opcode 3 (byte store) drives mask 2'b01 at an even pointer and 2'b10 at an odd pointer, with register bits 7:0 placed in both data lanes.
- R5: On the cycle after an access is granted, the pointer equals its old value plus the sign-extended step, modulo 2^16.
- R6: While a memory request is not granted, the request stays asserted, command ready stays low, the pointer does not change and no write-back appears.
- R7: A memory opcode (0 to 3) whose register index is 16 or above is accepted in one cycle. It issues no request and no write-back, and the pointer is unchanged.
- R8: Opcode 4 sets the pointer to the 12-bit immediate with bits 15:12 cleared, on the next cycle, and issues no request.
- R9: Opcode 5 replaces pointer bits 15:12 with immediate bits 3:0 and keeps bits 11:0, on the next cycle.
- R10: During and after reset the pointer is 0, there is no write-back and no memory request.
- R11: Opcodes 6 and 7 are accepted with no request, no write-back and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command consumed this cycle |
| cmd_op_i | input | 3 | Opcode |
| cmd_reg_i | input | 5 | Register index |
| cmd_val_i | input | 16 | Current register value |
| cmd_step_i | input | 8 | Signed pointer step |
| cmd_imm_i | input | 12 | Pointer immediate |
| ptr_o | output | 16 | Pointer register |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write request |
| mem_addr_o | output | 16 | Byte address |
| mem_be_o | output | 2 | Lane mask |
| mem_wdata_o | output | 16 | Write data |
| mem_gnt_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 16 | Read data, valid with grant |
| wb_valid_o | output | 1 | Write-back valid |
| wb_idx_o | output | 5 | Write-back register index |
| wb_data_o | output | 16 | Write-back value |

## Verification
The memory request, address, mask and write data are combinational from the command and the pointer. The bench checks them in the cycle the command is driven, one time unit after the inputs settle. The pointer and the write-back each pass through one register. They are due one clock after the grant or pointer command, and the bench checks them just after that edge. Stall runs hold the grant low for several cycles. Wrap cases cover a step taking the pointer past 16'hFFFF and a step taking it below zero.

// File: rtl/ptr_lsu_pkg.sv
package ptr_lsu_pkg;
  typedef enum logic [2:0] {
    OP_LDW = 3'd0,
    OP_STW = 3'd1,
    OP_LDB = 3'd2,
    OP_STB = 3'd3,
    OP_PLO = 3'd4,
    OP_PHI = 3'd5
  } op_e;
endpackage

// File: rtl/ptr_lsu_ptr.sv
module ptr_lsu_ptr #(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int IW = 12,
  parameter int HW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_en_i,
  input  logic [SW-1:0] step_i,
  input  logic          set_lo_i,
  input  logic          set_hi_i,
  input  logic [IW-1:0] imm_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_d, step_ext;

  assign step_ext = {{(AW-SW){step_i[SW-1]}}, step_i};

  always_comb begin
    ptr_d = ptr_q;
    if (step_en_i)     ptr_d = ptr_q + step_ext;
    else if (set_lo_i) ptr_d = {{(AW-IW){1'b0}}, imm_i};
    else if (set_hi_i) ptr_d = {imm_i[HW-1:0], ptr_q[AW-HW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ptr_lsu_lane.sv
module ptr_lsu_lane #(
  parameter int DW = 16
) (
  input  logic          is_byte_i,
  input  logic [LW-1:0] sel_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] rdata_i,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] ld_word_o,
  output logic [DW-1:0] ld_byte_o
);
  localparam int NB = DW / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  logic [7:0] rd_byte;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign be_o[b]          = !is_byte_i || (sel_i == LW'(b));
    assign wdata_o[b*8 +: 8] = is_byte_i ? val_i[7:0] : val_i[b*8 +: 8];
  end

  always_comb begin
    rd_byte = rdata_i[7:0];
    for (int b = 0; b < NB; b++)
      if (sel_i == LW'(b)) rd_byte = rdata_i[b*8 +: 8];
  end

  assign ld_word_o = rdata_i;
  assign ld_byte_o = {val_i[DW-1:8], rd_byte};
endmodule

// File: rtl/ptr_lsu_wb.sv
module ptr_lsu_wb #(
  parameter int DW  = 16,
  parameter int RIW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [RIW-1:0] idx_i,
  input  logic [DW-1:0]  data_i,
  output logic           valid_o,
  output logic [RIW-1:0] idx_o,
  output logic [DW-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        idx_o  <= idx_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/ptr_lsu.sv
module ptr_lsu #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SW      = 8,
  parameter int IW      = 12,
  parameter int HW      = 4,
  parameter int RIW     = 5,
  parameter int NUM_LSR = 16,
  localparam int NB = DW / 8,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  output logic           cmd_ready_o,
  input  logic [2:0]     cmd_op_i,
  input  logic [RIW-1:0] cmd_reg_i,
  input  logic [DW-1:0]  cmd_val_i,
  input  logic [SW-1:0]  cmd_step_i,
  input  logic [IW-1:0]  cmd_imm_i,
  output logic [AW-1:0]  ptr_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [NB-1:0]  mem_be_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_gnt_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           wb_valid_o,
  output logic [RIW-1:0] wb_idx_o,
  output logic [DW-1:0]  wb_data_o
);
  import ptr_lsu_pkg::*;

  op_e          op;
  logic         is_mem, is_byte, is_store, legal, done;
  logic [DW-1:0] ld_word, ld_byte, ld_val;

  assign op       = op_e'(cmd_op_i);
  assign is_mem   = (op == OP_LDW) || (op == OP_STW) || (op == OP_LDB) || (op == OP_STB);
  assign is_byte  = (op == OP_LDB) || (op == OP_STB);
  assign is_store = (op == OP_STW) || (op == OP_STB);
  assign legal    = cmd_reg_i < RIW'(NUM_LSR);

  assign mem_req_o   = cmd_valid_i && is_mem && legal;
  assign mem_we_o    = is_store;
  assign mem_addr_o  = ptr_o;
  assign done        = mem_req_o && mem_gnt_i;
  assign cmd_ready_o = !mem_req_o || mem_gnt_i;

  ptr_lsu_ptr #(.AW(AW), .SW(SW), .IW(IW), .HW(HW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_en_i (done),
    .step_i    (cmd_step_i),
    .set_lo_i  (cmd_valid_i && op == OP_PLO),
    .set_hi_i  (cmd_valid_i && op == OP_PHI),
    .imm_i     (cmd_imm_i),
    .ptr_o     (ptr_o)
  );

  ptr_lsu_lane #(.DW(DW)) u_lane (
    .is_byte_i (is_byte),
    .sel_i     (ptr_o[LW-1:0]),
    .val_i     (cmd_val_i),
    .rdata_i   (mem_rdata_i),
    .be_o      (mem_be_o),
    .wdata_o   (mem_wdata_o),
    .ld_word_o (ld_word),
    .ld_byte_o (ld_byte)
  );

  assign ld_val = is_byte ? ld_byte : ld_word;

  ptr_lsu_wb #(.DW(DW), .RIW(RIW)) u_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (done && !is_store),
    .idx_i   (cmd_reg_i),
    .data_i  (ld_val),
    .valid_o (wb_valid_o),
    .idx_o   (wb_idx_o),
    .data_o  (wb_data_o)
  );
endmodule

// File: rtl/ptr_lsu_chk.sv
module ptr_lsu_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int RIW = 5,
  parameter int NB = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_valid_i,
  input logic           cmd_ready_o,
  input logic [2:0]     cmd_op_i,
  input logic [RIW-1:0] cmd_reg_i,
  input logic [SW-1:0]  cmd_step_i,
  input logic [AW-1:0]  ptr_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic [NB-1:0]  mem_be_o,
  input logic           mem_gnt_i,
  input logic           wb_valid_o
);
  a_r1_addr_is_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == ptr_o);

  a_r4_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && cmd_op_i[1]) |-> $countones(mem_be_o) == 1);

  a_r5_post_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=>
      ptr_o == $past(ptr_o + {{(AW-SW){cmd_step_i[SW-1]}}, cmd_step_i}));

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> ($stable(ptr_o) && !wb_valid_o));

  a_r6_stall_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |-> !cmd_ready_o);

  a_r7_illegal_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_reg_i >= RIW'(16)) |-> !mem_req_o);

  a_r2_store_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && mem_we_o) |=> !wb_valid_o);

  a_r1_wb_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(mem_req_o && mem_gnt_i && !mem_we_o));
endmodule

bind ptr_lsu ptr_lsu_chk #(.AW(AW), .DW(DW), .SW(SW), .RIW(RIW), .NB(NB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .cmd_reg_i   (cmd_reg_i),
  .cmd_step_i  (cmd_step_i),
  .ptr_o       (ptr_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_gnt_i   (mem_gnt_i),
  .wb_valid_o  (wb_valid_o)
);

// File: tb/ptr_lsu_test.sv
module ptr_lsu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_val = '0;
  logic [7:0]  cmd_step = '0;
  logic [11:0] cmd_imm = '0;
  logic [15:0] ptr;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [1:0]  mem_be;
  logic        mem_gnt = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [15:0] wb_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_ptr = '0;
  logic        m_wbv = 1'b0;
  logic [4:0]  m_wbi = '0;
  logic [15:0] m_wbd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_lsu uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_reg_i(cmd_reg), .cmd_val_i(cmd_val),
    .cmd_step_i(cmd_step), .cmd_imm_i(cmd_imm), .ptr_o(ptr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .wb_valid_o(wb_valid), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic v, logic [2:0] op, logic [4:0] r,
                      logic [15:0] val, logic [7:0] st, logic [11:0] imm,
                      logic gnt, logic [15:0] rd);
    logic is_mem, e_req, e_we, e_ld;
    logic [1:0] e_be;
    logic [15:0] e_wd, e_ld_val;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_reg = r; cmd_val = val;
    cmd_step = st; cmd_imm = imm; mem_gnt = gnt; mem_rdata = rd;
    #1;
    is_mem = v && (op <= 3'd3) && (r < 5'd16);
    e_req  = is_mem;
    e_we   = (op == 3'd1) || (op == 3'd3);
    e_ld   = (op == 3'd0) || (op == 3'd2);
    chk(req, "req", 32'(mem_req), 32'(e_req));
    chk(req, "ready", 32'(cmd_ready), 32'(!e_req || gnt));
    if (e_req) begin
      if (op[1]) begin
        e_be = m_ptr[0] ? 2'b10 : 2'b01;
        e_wd = {val[7:0], val[7:0]};
        e_ld_val = {val[15:8], m_ptr[0] ? rd[15:8] : rd[7:0]};
      end else begin
        e_be = 2'b11; e_wd = val; e_ld_val = rd;
      end
      chk(req, "addr", 32'(mem_addr), 32'(m_ptr));
      chk(req, "we", 32'(mem_we), 32'(e_we));
      chk(req, "be", 32'(mem_be), 32'(e_be));
      if (e_we) chk(req, "wdata", 32'(mem_wdata), 32'(e_wd));
    end else e_ld_val = '0;
    @(posedge clk); #1;
    m_wbv = 1'b0;
    if (e_req && gnt) begin
      m_ptr = m_ptr + {{8{st[7]}}, st};
      if (e_ld) begin m_wbv = 1'b1; m_wbi = r; m_wbd = e_ld_val; end
    end else if (v && op == 3'd4) m_ptr = {4'h0, imm};
    else if (v && op == 3'd5) m_ptr = {imm[3:0], m_ptr[11:0]};
    chk(req, "ptr", 32'(ptr), 32'(m_ptr));
    chk(req, "wb_valid", 32'(wb_valid), 32'(m_wbv));
    if (m_wbv) begin
      chk(req, "wb_idx", 32'(wb_idx), 32'(m_wbi));
      chk(req, "wb_data", 32'(wb_data), 32'(m_wbd));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R10: reset state
    chk("R10", "ptr", 32'(ptr), 32'h0);
    chk("R10", "wb_valid", 32'(wb_valid), 32'h0);
    chk("R10", "req", 32'(mem_req), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step("R10", 0, 3'd0, 5'd0, 16'h0, 8'h0, 12'h0, 0, 16'h0);

    // R8, R9: pointer set
    step("R8", 1, 3'd4, 5'd0, 16'h0, 8'h0, 12'h123, 0, 16'h0);
    step("R9", 1, 3'd5, 5'd0, 16'h0, 8'h0, 12'hFA7, 0, 16'h0);
    step("R8", 1, 3'd4, 5'd0, 16'h0, 8'h0, 12'h100, 1, 16'h0);

    // R1 word load with stall (R6)
    step("R6", 1, 3'd0, 5'd3, 16'h0, 8'h02, 12'h0, 0, 16'hDEAD);
    step("R6", 1, 3'd0, 5'd3, 16'h0, 8'h02, 12'h0, 0, 16'hDEAD);
    step("R1", 1, 3'd0, 5'd3, 16'h0, 8'h02, 12'h0, 1, 16'hBEEF);
    // R2 word store, negative step (R5)
    step("R2", 1, 3'd1, 5'd4, 16'h5A5A, 8'hFE, 12'h0, 1, 16'h0);
    step("R5", 1, 3'd0, 5'd15, 16'h0, 8'h01, 12'h0, 1, 16'h1234);
    // R3 byte load, odd then even
    step("R3", 1, 3'd2, 5'd7, 16'hAB00, 8'h01, 12'h0, 1, 16'hC3D4);
    step("R3", 1, 3'd2, 5'd8, 16'h77FF, 8'h00, 12'h0, 1, 16'h1E2F);
    // R4 byte store even and odd
    step("R4", 1, 3'd3, 5'd1, 16'h9966, 8'hFF, 12'h0, 1, 16'h0);
    step("R4", 1, 3'd3, 5'd2, 16'h1133, 8'h10, 12'h0, 0, 16'h0);
    step("R4", 1, 3'd3, 5'd2, 16'h1133, 8'h10, 12'h0, 1, 16'h0);
    // R7 illegal register index
    step("R7", 1, 3'd0, 5'd16, 16'h0, 8'h05, 12'h0, 1, 16'hFFFF);
    step("R7", 1, 3'd3, 5'd31, 16'h00AA, 8'h05, 12'h0, 0, 16'h0);
    // R11 unused opcodes
    step("R11", 1, 3'd6, 5'd1, 16'h0, 8'h05, 12'hFFF, 1, 16'h0);
    step("R11", 1, 3'd7, 5'd1, 16'h0, 8'h05, 12'hFFF, 1, 16'h0);
    // R5 wrap above 16'hFFFF and below zero
    step("R8", 1, 3'd4, 5'd0, 16'h0, 8'h0, 12'hFFF, 0, 16'h0);
    step("R9", 1, 3'd5, 5'd0, 16'h0, 8'h0, 12'h00F, 0, 16'h0);
    step("R5", 1, 3'd0, 5'd9, 16'h0, 8'h03, 12'h0, 1, 16'h4321);
    step("R5", 1, 3'd1, 5'd9, 16'hCAFE, 8'h80, 12'h0, 1, 16'h0);
    step("R5", 1, 3'd2, 5'd9, 16'h0000, 8'h7F, 12'h0, 1, 16'h89AB);
    // back-to-back loads
    for (int i = 0; i < 6; i++)
      step("R1", 1, 3'd0, 5'(i), 16'h0, 8'(i + 1), 12'h0, 1, 16'(i * 16'h1111));
    step("R10", 0, 3'd0, 5'd0, 16'h0, 8'h0, 12'h0, 0, 16'h0);
    finish_run();
  end
endmodule